// File: doc/BRIEF.md
# Event Log Interrupt Policy Controller

This block keeps one interrupt enable for each of five device event logs (informational, warning, failure, fatal and dynamic capacity). A command port handles two requests. Get Policy returns the current settings as a five-byte payload. Set Policy loads new settings from a payload of four or five bytes. Each request gets a registered response with a payload, a length and a status code.

A notify trigger starts a scan of the logs. Every log that is enabled and holds records then raises a message-signalled interrupt request on its fixed vector. The requests are issued one pulse per clock, in ascending log order. Each pulse is tagged with the log index and with the message flavour: MSI-X when that is enabled, plain MSI otherwise. Record storage, the mailbox transport and message generation on the link belong to neighbouring blocks.

Top module: `evt_irq_policy_ctrl`

## Requirements
- R1: After reset, all five logs are disabled, so a Get response is all zero, and no vector pulse or busy flag is active.
- R2: A Get response always has length 5. Its byte k (bits 8k+7:8k) serves log k, in the order info=0, warn=1, failure=2, fatal=3, dynamic capacity=4. For an enabled log k<4 the byte is {vector(4 bits), 2'b00, 2'b01}, and the vector is 2+k. A disabled log's byte is 0x00.
- R3: In a Get response, byte 4 is 0x01 when the dynamic-capacity log is enabled. Its vector field stays zero.
- R4: On an accepted Set, log k<4 is enabled exactly when bits 8k+1:8k of the payload equal 1. The values 0, 2 and 3 disable it.
- R5: A Set of length 4 leaves the dynamic-capacity enable unchanged. A Set of length 5 or more loads that enable from bits 33:32 of the payload, using the same rule as R4.
- R6: A Set shorter than 4 bytes returns status 2 (invalid length) with response length 0, and changes no enable.
- R7: An opcode other than Get (0x02) or Set (0x03) returns status 1 (unsupported) with length 0 and a zero payload, and changes no enable.
- R8: A successful Get or Set returns status 0. The response length for Set is 5, and the Set response payload is zero.
- R9: On notify, each log that is both enabled and non-empty gets exactly one vector pulse, in ascending log index order, one per clock. The first pulse comes one clock after the trigger. The dynamic-capacity log pulses vector 2, the informational log's vector.
- R10: The pulse tag shows MSI-X when the MSI-X enable is set at the trigger, and MSI otherwise. If neither enable is set, no pulse is issued.
- R11: The busy flag is high from the first pulse to the last. A notify that arrives while busy is ignored.
- R12: Every command gets exactly one response-valid pulse, one clock after the command strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 8 | Opcode: 0x02 Get, 0x03 Set |
| cmd_data_i | input | 40 | Set payload, byte k at bits 8k+7:8k |
| cmd_len_i | input | 4 | Set payload length in bytes |
| log_nonempty_i | input | 5 | Per-log flag: the log holds records |
| msix_en_i | input | 1 | MSI-X enabled |
| msi_en_i | input | 1 | MSI enabled |
| notify_i | input | 1 | Start an interrupt scan |
| rsp_valid_o | output | 1 | Response strobe |
| rsp_data_o | output | 40 | Response payload |
| rsp_len_o | output | 4 | Response length in bytes |
| rsp_status_o | output | 2 | 0 success, 1 unsupported, 2 invalid length |
| vec_valid_o | output | 1 | Vector request pulse |
| vec_num_o | output | 4 | Vector number |
| vec_log_o | output | 3 | Index of the log that raised the request |
| vec_msix_o | output | 1 | 1: MSI-X, 0: MSI |
| busy_o | output | 1 | A scan sequence is in progress |

## Verification
Some properties are checked on every cycle:
- A response follows each strobe by exactly one clock.
- A short or unsupported command never touches an enable.
- A four-byte Set keeps the dynamic-capacity enable.
- Within one sequence, the pulses rise strictly in log order, and the flavour tag holds steady.
- A trigger with no message flavour enabled starts nothing.

The bench scenarios show the rest:
- The exact byte encodings of a Get response after mixed Sets.
- That the dynamic-capacity log shares vector 2.
- That the right subset of logs pulses for a given pattern of enables and records.
- That a trigger arriving mid-sequence leaves no trailing pulses.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
  localparam int NUM_LOGS    = 5;
  localparam int LOG_W       = $clog2(NUM_LOGS);
  localparam int VEC_W       = 4;
  localparam int VEC_BASE    = 2;
  localparam int OP_W        = 8;
  localparam int LEN_W       = 4;
  localparam int PAY_W       = NUM_LOGS * 8;
  localparam int MIN_SET_LEN = NUM_LOGS - 1;
  localparam int FULL_LEN    = NUM_LOGS;
  localparam int LOG_DCAP    = NUM_LOGS - 1;

  localparam logic [OP_W-1:0] OP_GET = 8'h02;
  localparam logic [OP_W-1:0] OP_SET = 8'h03;

  localparam logic [1:0] MODE_MSG = 2'd1;

  localparam logic [1:0] ST_OK      = 2'd0;
  localparam logic [1:0] ST_UNSUP   = 2'd1;
  localparam logic [1:0] ST_BAD_LEN = 2'd2;

  // dynamic capacity borrows the informational vector
  function automatic logic [VEC_W-1:0] vec_of(input logic [LOG_W-1:0] idx);
    if (idx == LOG_W'(LOG_DCAP)) return VEC_W'(VEC_BASE);
    return VEC_W'(VEC_BASE) + VEC_W'(idx);
  endfunction
endpackage

// File: rtl/evt_policy_regs.sv
module evt_policy_regs
  import evt_irq_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                set_i,
  input  logic                set_dcap_i,
  input  logic [PAY_W-1:0]    set_data_i,
  output logic [NUM_LOGS-1:0] en_o,
  output logic [PAY_W-1:0]    get_data_o
);
  logic [NUM_LOGS-1:0] en_q;

  for (genvar g = 0; g < NUM_LOGS; g++) begin : g_log
    logic upd;
    if (g == LOG_DCAP) begin : g_dcap
      assign upd = set_i && set_dcap_i;
      assign get_data_o[8*g +: 8] = en_q[g] ? {6'd0, MODE_MSG} : 8'd0;
    end else begin : g_std
      assign upd = set_i;
      assign get_data_o[8*g +: 8] =
        en_q[g] ? {vec_of(LOG_W'(g)), 2'b00, MODE_MSG} : 8'd0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  en_q[g] <= 1'b0;
      else if (upd) en_q[g] <= (set_data_i[8*g +: 2] == MODE_MSG);
    end
  end

  assign en_o = en_q;

  // R5
  dcap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && !set_dcap_i) |=> en_q[LOG_DCAP] == $past(en_q[LOG_DCAP]));

  // R4
  info_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> en_q[0] == ($past(set_data_i[1:0]) == MODE_MSG));
endmodule

// File: rtl/evt_notify_seq.sv
module evt_notify_seq
  import evt_irq_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                notify_i,
  input  logic [NUM_LOGS-1:0] qual_i,
  input  logic                msix_en_i,
  input  logic                msi_en_i,
  output logic                vec_valid_o,
  output logic [VEC_W-1:0]    vec_num_o,
  output logic [LOG_W-1:0]    vec_log_o,
  output logic                vec_msix_o,
  output logic                busy_o
);
  logic [NUM_LOGS-1:0] pend_q;
  logic                msix_q;
  logic [LOG_W-1:0]    pick;
  logic                start;

  assign start = notify_i && (pend_q == '0) && (msix_en_i || msi_en_i);

  always_comb begin
    pick = '0;
    for (int i = NUM_LOGS - 1; i >= 0; i--)
      if (pend_q[i]) pick = LOG_W'(i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      msix_q <= 1'b0;
    end else if (start) begin
      pend_q <= qual_i;
      msix_q <= msix_en_i;
    end else begin
      // drop lowest pending bit
      pend_q <= pend_q & (pend_q - NUM_LOGS'(1));
    end
  end

  assign vec_valid_o = |pend_q;
  assign busy_o      = |pend_q;
  assign vec_log_o   = pick;
  assign vec_num_o   = vec_of(pick);
  assign vec_msix_o  = msix_q;

  // R9
  ascend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_valid_o |=> (!vec_valid_o || vec_log_o > $past(vec_log_o)));

  // R10
  no_flavour_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !msix_en_i && !msi_en_i) |=> !vec_valid_o);

  // R11
  tag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && vec_valid_o) |=> (!busy_o || vec_msix_o == $past(vec_msix_o)));
endmodule

// File: rtl/evt_irq_policy_ctrl.sv
module evt_irq_policy_ctrl
  import evt_irq_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cmd_valid_i,
  input  logic [OP_W-1:0]     cmd_op_i,
  input  logic [PAY_W-1:0]    cmd_data_i,
  input  logic [LEN_W-1:0]    cmd_len_i,
  input  logic [NUM_LOGS-1:0] log_nonempty_i,
  input  logic                msix_en_i,
  input  logic                msi_en_i,
  input  logic                notify_i,
  output logic                rsp_valid_o,
  output logic [PAY_W-1:0]    rsp_data_o,
  output logic [LEN_W-1:0]    rsp_len_o,
  output logic [1:0]          rsp_status_o,
  output logic                vec_valid_o,
  output logic [VEC_W-1:0]    vec_num_o,
  output logic [LOG_W-1:0]    vec_log_o,
  output logic                vec_msix_o,
  output logic                busy_o
);
  logic                is_get, is_set, len_ok, set_go, set_dcap;
  logic [NUM_LOGS-1:0] en;
  logic [PAY_W-1:0]    get_data;

  logic             rsp_valid_q;
  logic [PAY_W-1:0] rsp_data_q;
  logic [LEN_W-1:0] rsp_len_q;
  logic [1:0]       rsp_status_q;

  assign is_get   = cmd_op_i == OP_GET;
  assign is_set   = cmd_op_i == OP_SET;
  assign len_ok   = cmd_len_i >= LEN_W'(MIN_SET_LEN);
  assign set_dcap = cmd_len_i >= LEN_W'(FULL_LEN);
  assign set_go   = cmd_valid_i && is_set && len_ok;

  evt_policy_regs u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (set_go),
    .set_dcap_i (set_dcap),
    .set_data_i (cmd_data_i),
    .en_o       (en),
    .get_data_o (get_data)
  );

  evt_notify_seq u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .notify_i    (notify_i),
    .qual_i      (en & log_nonempty_i),
    .msix_en_i   (msix_en_i),
    .msi_en_i    (msi_en_i),
    .vec_valid_o (vec_valid_o),
    .vec_num_o   (vec_num_o),
    .vec_log_o   (vec_log_o),
    .vec_msix_o  (vec_msix_o),
    .busy_o      (busy_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q  <= 1'b0;
      rsp_data_q   <= '0;
      rsp_len_q    <= '0;
      rsp_status_q <= ST_OK;
    end else begin
      rsp_valid_q <= cmd_valid_i;
      if (cmd_valid_i) begin
        rsp_data_q <= '0;
        rsp_len_q  <= '0;
        if (is_get) begin
          rsp_data_q   <= get_data;
          rsp_len_q    <= LEN_W'(FULL_LEN);
          rsp_status_q <= ST_OK;
        end else if (is_set) begin
          rsp_status_q <= len_ok ? ST_OK : ST_BAD_LEN;
          rsp_len_q    <= len_ok ? LEN_W'(FULL_LEN) : '0;
        end else begin
          rsp_status_q <= ST_UNSUP;
        end
      end
    end
  end

  assign rsp_valid_o  = rsp_valid_q;
  assign rsp_data_o   = rsp_data_q;
  assign rsp_len_o    = rsp_len_q;
  assign rsp_status_o = rsp_status_q;

  // R12
  rsp_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i |=> rsp_valid_o);

  // R12
  rsp_spur_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_valid_i |=> !rsp_valid_o);

  // R7
  unsup_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && !is_get && !is_set) |=> (en == $past(en) && rsp_status_o == ST_UNSUP));

  // R6
  short_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && is_set && !len_ok) |=> (en == $past(en) && rsp_status_o == ST_BAD_LEN));
endmodule

// File: tb/evt_irq_policy_ctrl_test.sv
`timescale 1ns/1ps
module evt_irq_policy_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [7:0]  cmd_op = '0;
  logic [39:0] cmd_data = '0;
  logic [3:0]  cmd_len = '0;
  logic [4:0]  nonempty = '0;
  logic        msix_en = 1'b0, msi_en = 1'b0, notify = 1'b0;
  logic        rsp_valid, vec_valid, vec_msix, busy;
  logic [39:0] rsp_data;
  logic [3:0]  rsp_len, vec_num;
  logic [1:0]  rsp_status;
  logic [2:0]  vec_log;

  int n_chk = 0, n_fail = 0;
  logic [4:0] m_en = '0;

  always #5 clk = ~clk;

  evt_irq_policy_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
    .cmd_data_i(cmd_data), .cmd_len_i(cmd_len), .log_nonempty_i(nonempty),
    .msix_en_i(msix_en), .msi_en_i(msi_en), .notify_i(notify),
    .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data), .rsp_len_o(rsp_len),
    .rsp_status_o(rsp_status), .vec_valid_o(vec_valid), .vec_num_o(vec_num),
    .vec_log_o(vec_log), .vec_msix_o(vec_msix), .busy_o(busy)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_vec(input int k);
    return (k == 4) ? 4'd2 : 4'(2 + k);
  endfunction

  function automatic logic [39:0] exp_get(input logic [4:0] en);
    logic [39:0] r = '0;
    for (int k = 0; k < 4; k++)
      if (en[k]) r[8*k +: 8] = {exp_vec(k), 4'b0001};
    if (en[4]) r[39:32] = 8'h01;
    return r;
  endfunction

  task automatic do_cmd(input logic [7:0] op, input logic [39:0] d,
                        input logic [3:0] len, input string req);
    logic [1:0]  e_st;
    logic [3:0]  e_len;
    logic [39:0] e_dat = '0;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_data = d; cmd_len = len;
    if (op == 8'h02) begin
      e_st = 2'd0; e_len = 4'd5; e_dat = exp_get(m_en);
    end else if (op == 8'h03) begin
      if (len < 4) begin
        e_st = 2'd2; e_len = 4'd0;
      end else begin
        e_st = 2'd0; e_len = 4'd5;
        for (int k = 0; k < 4; k++) m_en[k] = (d[8*k +: 2] == 2'd1);
        if (len >= 5) m_en[4] = (d[33:32] == 2'd1);
      end
    end else begin
      e_st = 2'd1; e_len = 4'd0;
    end
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(rsp_valid == 1'b1, "R12", "rsp_valid", rsp_valid, 1);
    chk(rsp_status == e_st, req, "status", rsp_status, e_st);
    chk(rsp_len == e_len, req, "len", rsp_len, e_len);
    chk(rsp_data == e_dat, req, "data", rsp_data, e_dat);
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R12", "rsp_valid drop", rsp_valid, 0);
  endtask

  task automatic get_chk(input string req);
    do_cmd(8'h02, 40'd0, 4'd0, req);
  endtask

  task automatic do_notify(input logic [4:0] ne, input bit mx, input bit ms,
                           input bit poke);
    logic [4:0] q = (mx || ms) ? (m_en & ne) : 5'd0;
    @(negedge clk);
    nonempty = ne; msix_en = mx; msi_en = ms; notify = 1'b1;
    @(negedge clk);
    notify = 1'b0;
    for (int k = 0; k < 5; k++) begin
      if (q[k]) begin
        chk(vec_valid == 1'b1, "R9", "vec_valid", vec_valid, 1);
        chk(vec_log == 3'(k), "R9", "vec_log", vec_log, k);
        chk(vec_num == exp_vec(k), "R9", "vec_num", vec_num, exp_vec(k));
        chk(vec_msix == mx, "R10", "vec_msix", vec_msix, mx);
        chk(busy == 1'b1, "R11", "busy", busy, 1);
        if (poke) begin
          notify = 1'b1; nonempty = 5'h1f;
          poke = 1'b0;
        end
        @(negedge clk);
        notify = 1'b0;
      end
    end
    chk(vec_valid == 1'b0, "R9", "sequence end", vec_valid, 0);
    chk(busy == 1'b0, "R11", "busy end", busy, 0);
    @(negedge clk);
    chk(vec_valid == 1'b0, "R11", "no late pulse", vec_valid, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk(rsp_valid == 0, "R1", "reset rsp_valid", rsp_valid, 0);
    chk(vec_valid == 0, "R1", "reset vec_valid", vec_valid, 0);
    chk(busy == 0, "R1", "reset busy", busy, 0);
    rst_n = 1'b1;
    get_chk("R1");

    // all on, full length
    do_cmd(8'h03, 40'h01_01_01_01_01, 4'd5, "R8");
    get_chk("R2");
    do_notify(5'h1f, 1'b1, 1'b1, 1'b0);
    // mixed modes, length 4: dcap must stay on
    do_cmd(8'h03, 40'h00_01_00_03_02, 4'd4, "R4");
    get_chk("R5");
    chk(rsp_data[39:32] == 8'h01, "R3", "dcap byte", rsp_data[39:32], 8'h01);
    // short set rejected
    do_cmd(8'h03, 40'h00_00_00_00_00, 4'd3, "R6");
    get_chk("R6");
    // unsupported opcode
    do_cmd(8'h7e, 40'h00_00_00_00_00, 4'd5, "R7");
    get_chk("R7");
    // dcap off via fifth byte
    do_cmd(8'h03, 40'h02_01_01_01_01, 4'd5, "R5");
    get_chk("R5");
    do_cmd(8'h03, 40'h01_01_00_00_01, 4'd5, "R4");
    do_notify(5'h1f, 1'b0, 1'b1, 1'b0);   // MSI only
    do_notify(5'h1f, 1'b0, 1'b0, 1'b0);   // R10 nothing
    do_notify(5'h1f, 1'b1, 1'b0, 1'b1);   // R11 poke while busy
    do_notify(5'h10, 1'b1, 1'b0, 1'b0);   // R9 dcap on vector 2

    for (int i = 0; i < 300; i++) begin
      int sel = $urandom_range(0, 9);
      logic [39:0] d = {8'($urandom), $urandom};
      if (sel < 3) get_chk("R2");
      else if (sel < 6) do_cmd(8'h03, d, 4'($urandom_range(2, 7)), "R4");
      else if (sel == 6) do_cmd(8'($urandom_range(4, 255)), d, 4'd5, "R7");
      else do_notify(5'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule